// File: doc/BRIEF.md
# Serial Audio Link Output Frame Serializer

This block is the transmit side of a serial audio link, clocked directly by the link's bit clock. It produces a frame strobe and a single serial data line. Every frame is 256 bit clocks long: a 16-bit tag slot followed by twelve 20-bit data slots. A 12.288 MHz bit clock therefore gives a 48 kHz frame rate. The strobe is high for exactly the 16 clocks of the tag phase. Outputs change only on the rising clock edge, so the receiving side can sample on the falling edge.

A producer offers the next frame as a per-slot valid mask and twelve 20-bit payloads, qualified by a valid/ready handshake. The serializer captures the contents once per frame, at the boundary, and builds the tag word from the mask. It then shifts the tag and every slot out MSB first, and drives every bit of a slot marked invalid as zero. A halt input parks the link between frames, with the strobe and the data line held low, to save power.

The sequencer has three states. `ST_IDLE` is the parked state. `ST_TAG` covers the 16 tag bits. `ST_DATA` covers the 240 slot bits. The transitions are:
- `IDLE->TAG` when halt is low.
- `TAG->TAG` while tag bits remain.
- `TAG->DATA` after tag bit 0.
- `DATA->DATA` while slot bits remain.
- `DATA->TAG` after the last bit of slot 12 when halt is low.
- `DATA->IDLE` at the same point when halt is high.
- `IDLE->IDLE` while halt is high.

Top module: `aclink_tx`

## Requirements
- R1: While running, a new frame starts every 256 clocks, back to back, with no gap between frames.
- R2: `sync_o` rises on the clock edge that starts a frame and stays high for exactly 16 clocks, then stays low for the rest of the frame.
- R3: `sdo_o` carries tag bit 15 one edge after the edge that raised `sync_o`. Tag bit 15 is 1 exactly when the captured mask has at least one bit set.
- R4: The next tag bits, 14 down to 3, are mask bits 0 to 11 (slots 1 to 12) in that order. Tag bits 2 to 0 are 0.
- R5: After the tag, slots 1 to 12 follow in order. Slot k is `slot_data_i[(k-1)*20 +: 20]`, and each slot is sent from its bit 19 down to bit 0, so short samples must be MSB-justified with zeroed low bits.
- R6: Every bit of a slot whose mask bit is 0 is sent as 0, whatever its payload.
- R7: The mask and payloads are captured on the edge where `frm_ready_o` and `frm_valid_i` are both high. Input changes at any other time have no effect on the frame. If `frm_ready_o` is high and `frm_valid_i` is low, the frame is sent with an all-zero mask.
- R8: `frm_ready_o` is high only when `halt_i` is low and the link is either parked or presenting the last bit of slot 12.
- R9: `halt_i` is acted on only at a frame boundary. The current frame completes, and from the second edge after its end `sync_o` and `sdo_o` stay low until halt is released. A halt pulse that ends before the boundary has no effect.
- R10: During and right after reset the link is parked, with `sync_o` and `sdo_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Park the link at the next frame boundary |
| frm_valid_i | input | 1 | Producer offers the next frame's contents |
| frm_ready_o | output | 1 | Serializer captures the offered contents on this edge |
| slot_valid_i | input | 12 | Per-slot valid mask, bit i for slot i+1 |
| slot_data_i | input | 240 | Slot payloads, slot i+1 in bits [i*20 +: 20] |
| sync_o | output | 1 | Frame strobe, high during the tag phase |
| sdo_o | output | 1 | Serial frame data, MSB first |

## Verification
`sync_o` follows the sequencer state register directly: it changes on the same edge that enters or leaves the tag phase. `sdo_o` lags by one edge, so frame position p appears on the edge after the one where the state reached p, and tag bit 15 appears one edge after `sync_o` rises. `frm_ready_o` is combinational from the state and `halt_i`, so it is valid in the same cycle. The bench steps a position-based model once per rising edge, using the inputs that were held across that edge. It compares `sync_o` and `sdo_o` at the next falling edge. It drives new inputs there and compares `frm_ready_o` a quarter period later. The random payloads are redrawn every cycle, so any capture outside the handshake edge would show up as a data mismatch.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int TAG_BITS  = 16;
    localparam int SLOT_BITS = 20;
    localparam int NUM_SLOTS = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;
endpackage

// File: rtl/aclink_frame_latch.sv
module aclink_frame_latch #(
    parameter int N_SLOTS = aclink_pkg::NUM_SLOTS,
    parameter int SLOT_W  = aclink_pkg::SLOT_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      take_i,
    input  logic [N_SLOTS-1:0]        mask_i,
    input  logic [N_SLOTS*SLOT_W-1:0] data_i,
    output logic [N_SLOTS-1:0]        mask_q,
    output logic [SLOT_W-1:0]         data_q [N_SLOTS]
);
    // Mask: a boundary without an offer yields an empty frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load_i) begin
            mask_q <= take_i ? mask_i : '0;
        end
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[s] <= '0;
            end else if (load_i && take_i) begin
                data_q[s] <= data_i[s*SLOT_W +: SLOT_W];
            end
        end
    end
endmodule

// File: rtl/aclink_tag_gen.sv
module aclink_tag_gen #(
    parameter int N_SLOTS = aclink_pkg::NUM_SLOTS,
    parameter int TAG_W   = aclink_pkg::TAG_BITS
) (
    input  logic [N_SLOTS-1:0] mask_i,
    output logic [TAG_W-1:0]   tag_o
);
    localparam int PAD_W = TAG_W - 1 - N_SLOTS;

    // Frame-valid flag in the top bit.
    assign tag_o[TAG_W-1] = |mask_i;

    // Slot flags in slot order, directly below the frame-valid flag.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_flag
        assign tag_o[TAG_W-2-i] = mask_i[i];
    end

    for (genvar j = 0; j < PAD_W; j++) begin : g_pad
        assign tag_o[j] = 1'b0;
    end
endmodule

// File: rtl/aclink_seq.sv
module aclink_seq
    import aclink_pkg::*;
#(
    parameter int TAG_W   = aclink_pkg::TAG_BITS,
    parameter int SLOT_W  = aclink_pkg::SLOT_BITS,
    parameter int N_SLOTS = aclink_pkg::NUM_SLOTS,
    localparam int TB_W   = $clog2(TAG_W),
    localparam int SI_W   = $clog2(N_SLOTS),
    localparam int BI_W   = $clog2(SLOT_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_i,
    input  logic            bit_i,
    output logic            frm_ready_o,
    output logic            sync_o,
    output logic            sdo_o,
    output logic            tag_phase_o,
    output logic [TB_W-1:0] tag_bit_o,
    output logic [SI_W-1:0] slot_o,
    output logic [BI_W-1:0] bit_o
);
    seq_state_t state, nstate;
    logic       last_bit;

    assign last_bit    = (state == ST_DATA) && (slot_o == SI_W'(N_SLOTS - 1))
                         && (bit_o == '0);
    assign frm_ready_o = !halt_i && ((state == ST_IDLE) || last_bit);
    assign tag_phase_o = (state == ST_TAG);

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: nstate = halt_i ? ST_IDLE : ST_TAG;
            ST_TAG:  nstate = (tag_bit_o == '0) ? ST_DATA : ST_TAG;
            ST_DATA: begin
                if (last_bit) nstate = halt_i ? ST_IDLE : ST_TAG;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // State register with its position counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tag_bit_o <= '0;
            slot_o    <= '0;
            bit_o     <= '0;
        end else begin
            state <= nstate;
            if (nstate == ST_TAG && state != ST_TAG) begin
                tag_bit_o <= TB_W'(TAG_W - 1);
            end else if (state == ST_TAG) begin
                tag_bit_o <= tag_bit_o - 1'b1;
            end
            if (state == ST_TAG && nstate == ST_DATA) begin
                slot_o <= '0;
                bit_o  <= BI_W'(SLOT_W - 1);
            end else if (state == ST_DATA) begin
                if (bit_o == '0) begin
                    slot_o <= slot_o + 1'b1;
                    bit_o  <= BI_W'(SLOT_W - 1);
                end else begin
                    bit_o <= bit_o - 1'b1;
                end
            end
        end
    end

    // Registered link outputs: strobe tracks the next state, data lags one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_o <= 1'b0;
            sdo_o  <= 1'b0;
        end else begin
            sync_o <= (nstate == ST_TAG);
            sdo_o  <= (state == ST_IDLE) ? 1'b0 : bit_i;
        end
    end
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx #(
    parameter int TAG_W   = aclink_pkg::TAG_BITS,
    parameter int SLOT_W  = aclink_pkg::SLOT_BITS,
    parameter int N_SLOTS = aclink_pkg::NUM_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      halt_i,
    input  logic                      frm_valid_i,
    output logic                      frm_ready_o,
    input  logic [N_SLOTS-1:0]        slot_valid_i,
    input  logic [N_SLOTS*SLOT_W-1:0] slot_data_i,
    output logic                      sync_o,
    output logic                      sdo_o
);
    localparam int TB_W = $clog2(TAG_W);
    localparam int SI_W = $clog2(N_SLOTS);
    localparam int BI_W = $clog2(SLOT_W);

    logic [N_SLOTS-1:0] vmask_q;
    logic [SLOT_W-1:0]  slot_q [N_SLOTS];
    logic [TAG_W-1:0]   tag_w;
    logic               tag_phase;
    logic [TB_W-1:0]    tag_bit;
    logic [SI_W-1:0]    slot_idx;
    logic [BI_W-1:0]    bit_idx;
    logic               cur_bit;

    aclink_frame_latch #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (frm_ready_o),
        .take_i (frm_valid_i),
        .mask_i (slot_valid_i),
        .data_i (slot_data_i),
        .mask_q (vmask_q),
        .data_q (slot_q)
    );

    aclink_tag_gen #(.N_SLOTS(N_SLOTS), .TAG_W(TAG_W)) u_tag (
        .mask_i (vmask_q),
        .tag_o  (tag_w)
    );

    // Bit under the sequencer's position; invalid slots read as zero.
    always_comb begin
        if (tag_phase) begin
            cur_bit = tag_w[tag_bit];
        end else begin
            cur_bit = vmask_q[slot_idx] & slot_q[slot_idx][bit_idx];
        end
    end

    aclink_seq #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (halt_i),
        .bit_i       (cur_bit),
        .frm_ready_o (frm_ready_o),
        .sync_o      (sync_o),
        .sdo_o       (sdo_o),
        .tag_phase_o (tag_phase),
        .tag_bit_o   (tag_bit),
        .slot_o      (slot_idx),
        .bit_o       (bit_idx)
    );
endmodule

// File: rtl/aclink_tx_chk.sv
module aclink_tx_chk #(
    parameter int TAG_W   = aclink_pkg::TAG_BITS,
    parameter int SLOT_W  = aclink_pkg::SLOT_BITS,
    parameter int N_SLOTS = aclink_pkg::NUM_SLOTS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               halt_i,
    input logic               frm_ready_o,
    input logic               sync_o,
    input logic               sdo_o,
    input logic [N_SLOTS-1:0] mask_q
);
    localparam int DATA_LEN = SLOT_W * N_SLOTS;
    localparam int CW       = $clog2(DATA_LEN + 2) + 1;

    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= sync_o ? hi_cnt + 1'b1 : '0;
            if (sync_o) lo_cnt <= '0;
            else if (lo_cnt <= CW'(DATA_LEN)) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R2: strobe never exceeds the tag length and always lasts exactly that long.
    p_sync_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= CW'(TAG_W));
    p_sync_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> hi_cnt == CW'(TAG_W));

    // R8: a frame only starts after a handshake slot, and ready stays low during halt.
    p_ready_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready_o |-> !halt_i);
    p_start_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(frm_ready_o));

    // R3: first bit after the strobe rises is the frame-valid flag.
    p_frame_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && hi_cnt == CW'(1)) |-> (sdo_o == (|mask_q)));

    // R6: an empty frame carries only zeros from its first tag bit on.
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && sync_o && hi_cnt != '0) |-> !sdo_o);

    // R9: once parked past the trailing bit, the data line stays low.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_cnt > CW'(DATA_LEN)) |-> !sdo_o);
endmodule

bind aclink_tx aclink_tx_chk #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_i      (halt_i),
    .frm_ready_o (frm_ready_o),
    .sync_o      (sync_o),
    .sdo_o       (sdo_o),
    .mask_q      (vmask_q)
);

// File: tb/aclink_tx_tb.sv
`timescale 1ns/1ps
module aclink_tx_tb;
    localparam int NS   = 12;
    localparam int SW   = 20;
    localparam int DW   = NS * SW;
    localparam int RUN  = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_i = 1'b1;
    logic          frm_valid_i = 1'b0;
    logic          frm_ready_o;
    logic [NS-1:0] slot_valid_i = '0;
    logic [DW-1:0] slot_data_i = '0;
    logic          sync_o;
    logic          sdo_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state: position in frame (-1 parked) and captured contents.
    int            m_pos = -1;
    logic [NS-1:0] m_mask = '0;
    logic [DW-1:0] m_data = '0;
    logic          e_sync, e_sdo;
    string         e_tag;
    int            bnd = 0;

    always #2 clk = ~clk;

    aclink_tx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_i       (halt_i),
        .frm_valid_i  (frm_valid_i),
        .frm_ready_o  (frm_ready_o),
        .slot_valid_i (slot_valid_i),
        .slot_data_i  (slot_data_i),
        .sync_o       (sync_o),
        .sdo_o        (sdo_o)
    );

    function automatic logic ref_bit(int p, logic [NS-1:0] mk, logic [DW-1:0] d);
        int s, b;
        if (p == 0) return |mk;
        if (p <= NS) return mk[p-1];
        if (p < 16) return 1'b0;
        s = (p - 16) / SW;
        b = SW - 1 - ((p - 16) % SW);
        return mk[s] & d[s*SW + b];
    endfunction

    function automatic string tag_of(int p, logic [NS-1:0] mk);
        if (p < 0)   return "R9";
        if (p == 0)  return "R3";
        if (p < 16)  return "R4";
        if (mk[(p - 16) / SW]) return "R5 R7";
        return "R6";
    endfunction

    function automatic logic [DW-1:0] rand_data(bit justify8);
        logic [DW-1:0] d;
        logic [SW-1:0] w;
        for (int s = 0; s < NS; s++) begin
            w = SW'($urandom);
            if (justify8) w[SW-9:0] = '0;
            d[s*SW +: SW] = w;
        end
        return d;
    endfunction

    function automatic logic model_ready();
        return (m_pos == -1 || m_pos == 255) && !halt_i;
    endfunction

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (pos %0d)", req, act, exp, m_pos);
        end
    endtask

    // One rising edge of the model, using the inputs held across that edge.
    task automatic model_step();
        logic r;
        r     = model_ready();
        e_sdo = (m_pos < 0) ? 1'b0 : ref_bit(m_pos, m_mask, m_data);
        e_tag = tag_of(m_pos, m_mask);
        if (r) begin
            m_mask = frm_valid_i ? slot_valid_i : '0;
            if (frm_valid_i) m_data = slot_data_i;
            m_pos = 0;
        end else if (m_pos == 255) begin
            m_pos = -1;
        end else if (m_pos >= 0) begin
            m_pos++;
        end
        e_sync = (m_pos >= 0 && m_pos < 16);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R10: parked during reset.
        check1("R10 sync", sync_o, 1'b0);
        check1("R10 sdo", sdo_o, 1'b0);
        check1("R10 ready", frm_ready_o, 1'b0);
        rst_n  = 1'b1;
        halt_i = 1'b0;
        frm_valid_i  = 1'b1;
        slot_valid_i = 12'hFFF;
        slot_data_i  = rand_data(1'b1);
        #1;
        check1("R8 ready after reset", frm_ready_o, 1'b1);

        for (int cyc = 0; cyc < RUN; cyc++) begin
            @(negedge clk);
            model_step();
            check1("R1 R2 sync", sync_o, e_sync);
            check1(e_tag, sdo_o, e_sdo);

            halt_i = ((cyc >= 1700 && cyc < 2400) || (cyc >= 3000 && cyc < 3010));
            if (m_pos == 255 || m_pos == -1) begin
                // Directed contents for the first boundaries, random afterwards.
                unique case (bnd)
                    0: begin frm_valid_i = 1; slot_valid_i = 12'hFFF; slot_data_i = rand_data(1); end
                    1: begin frm_valid_i = 1; slot_valid_i = 12'h000; slot_data_i = rand_data(0); end
                    2: begin frm_valid_i = 0; slot_valid_i = 12'hFFF; slot_data_i = rand_data(0); end
                    3: begin frm_valid_i = 1; slot_valid_i = 12'h001; slot_data_i = rand_data(0); end
                    4: begin frm_valid_i = 1; slot_valid_i = 12'h800; slot_data_i = rand_data(0); end
                    default: begin
                        frm_valid_i  = ($urandom % 4) != 0;
                        slot_valid_i = NS'($urandom);
                        slot_data_i  = rand_data(1'($urandom));
                    end
                endcase
                if (!halt_i) bnd++;
            end else begin
                // R7: contents redrawn mid-frame must not reach the line.
                frm_valid_i  = 1'($urandom);
                slot_valid_i = NS'($urandom);
                slot_data_i  = rand_data(0);
            end
            #1;
            check1("R8 ready", frm_ready_o, model_ready());
        end
        finish_run();
    end
endmodule